// File: doc/BRIEF.md
# Boundary test access port controller

This block is the serial test port of a chip: a four-wire controller that walks the standard sixteen-state machine under TMS, with a three-bit instruction register and three data paths. The data paths are a one-stage bypass, a 32-bit identity word and a snapshot register. The snapshot register takes a parallel copy of a core-supplied input vector whose width is a parameter. An external tester loads an instruction, then captures and shifts the selected data path to read the identity or a sample of the core's pins.

TDI and TMS are taken on the rising edge of TCK. TDO and its enable change only on the falling edge. The enable is high only while a shift state is current, so the pad can float the line at all other times. While the sample-with-float instruction is active, the `outputs_hiz` output tells the core to float its data and match outputs. An active-low asynchronous reset stands in for power-up.

Top module: `tap_port`

## Requirements
- R1: While `trst_n` is low, the controller is held in Test-Logic-Reset with `tdo_en` = 0, `outputs_hiz` = 0 and the active instruction set to the identity code (1).
- R2: State moves follow the standard sixteen-state TMS graph on each rising TCK edge, including the Pause-IR/Pause-DR detours back into shifting.
- R3: Five consecutive rising edges with TMS = 1 reach Test-Logic-Reset from any state, and this reloads the identity instruction. Four such edges taken from Shift-DR do not.
- R4: `tdo_en` is 1 exactly while the current state is Shift-IR or Shift-DR, and it and `tdo` change only on falling TCK edges.
- R5: In every register, TDI enters the least significant bit on each shift edge, and the most significant bit drives `tdo`. The first bit out after a capture is therefore the captured MSB.
- R6: Capture-IR loads the instruction shift stage with binary 001. A shifted-in code becomes active only when Update-IR is left, and the active instruction is unchanged through shifting and Pause-IR.
- R7: Instruction codes 0, 3, 6 and 7 and the private code 5 select the bypass stage. Code 1 selects the identity word. Codes 2 and 4 select the snapshot register.
- R8: The bypass stage is one bit long and captures 0 in Capture-DR.
- R9: The identity word is {revision[3:0] at bits 31:28, part[15:0] at bits 27:12, maker[10:0] at bits 11:1, 1 at bit 0}, each field a parameter.
- R10: Under codes 2 and 4, Capture-DR copies `sample_in` into a SAMPLE_W-bit register. Changes to `sample_in` after capture do not affect the shifted-out data.
- R11: `outputs_hiz` is 1 while code 2 is the active instruction and 0 under every other code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous active-low reset (power-up) |
| tms | input | 1 | Mode select, sampled on rising TCK |
| tdi | input | 1 | Serial data in, sampled on rising TCK |
| sample_in | input | SAMPLE_W | Parallel vector copied by the snapshot register |
| tdo | output | 1 | Serial data out, updated on falling TCK |
| tdo_en | output | 1 | Drive enable for the TDO pad |
| outputs_hiz | output | 1 | Request to float core data and match outputs |

## Verification
The bench builds the block with SAMPLE_W = 12 and identity fields of revision 9, part C3A1 and maker 2B5 (hex). These values make the three data paths 1, 12 and 32 bits long. Any wrong selection therefore shows up as a length or content mismatch, and the asymmetric bit patterns expose a reversed shift direction. The 12-bit snapshot length also allows a mid-shift change of `sample_in`, which tests that the captured value is held.

// File: rtl/tap_port_pkg.sv
package tap_port_pkg;

    localparam int IR_W = 3;
    localparam int ID_W = 32;

    typedef enum logic [3:0] {
        ST_RESET, ST_IDLE,
        ST_SEL_DR, ST_CAP_DR, ST_SH_DR, ST_EX1_DR, ST_PAU_DR, ST_EX2_DR, ST_UPD_DR,
        ST_SEL_IR, ST_CAP_IR, ST_SH_IR, ST_EX1_IR, ST_PAU_IR, ST_EX2_IR, ST_UPD_IR
    } tap_st_e;

    typedef enum logic [IR_W-1:0] {
        OP_BYP0 = 3'd0,
        OP_IDC  = 3'd1,
        OP_SAMZ = 3'd2,
        OP_BYP3 = 3'd3,
        OP_SAMP = 3'd4,
        OP_PRIV = 3'd5,
        OP_BYP6 = 3'd6,
        OP_BYP7 = 3'd7
    } op_e;

    typedef enum logic [1:0] {
        PATH_BYP,
        PATH_ID,
        PATH_SMP
    } dr_path_e;

    localparam logic [IR_W-1:0] IR_CAPTURE = 3'b001;

    function automatic tap_st_e tap_next(input tap_st_e st, input logic m);
        tap_st_e nx;
        case (st)
            ST_RESET:  nx = m ? ST_RESET  : ST_IDLE;
            ST_IDLE:   nx = m ? ST_SEL_DR : ST_IDLE;
            ST_SEL_DR: nx = m ? ST_SEL_IR : ST_CAP_DR;
            ST_CAP_DR: nx = m ? ST_EX1_DR : ST_SH_DR;
            ST_SH_DR:  nx = m ? ST_EX1_DR : ST_SH_DR;
            ST_EX1_DR: nx = m ? ST_UPD_DR : ST_PAU_DR;
            ST_PAU_DR: nx = m ? ST_EX2_DR : ST_PAU_DR;
            ST_EX2_DR: nx = m ? ST_UPD_DR : ST_SH_DR;
            ST_UPD_DR: nx = m ? ST_SEL_DR : ST_IDLE;
            ST_SEL_IR: nx = m ? ST_RESET  : ST_CAP_IR;
            ST_CAP_IR: nx = m ? ST_EX1_IR : ST_SH_IR;
            ST_SH_IR:  nx = m ? ST_EX1_IR : ST_SH_IR;
            ST_EX1_IR: nx = m ? ST_UPD_IR : ST_PAU_IR;
            ST_PAU_IR: nx = m ? ST_EX2_IR : ST_PAU_IR;
            ST_EX2_IR: nx = m ? ST_UPD_IR : ST_SH_IR;
            ST_UPD_IR: nx = m ? ST_SEL_DR : ST_IDLE;
            default:   nx = ST_RESET;
        endcase
        return nx;
    endfunction

endpackage

// File: rtl/tap_port_fsm.sv
module tap_port_fsm
    import tap_port_pkg::*;
(
    input  logic    tck,
    input  logic    trst_n,
    input  logic    tms,
    output tap_st_e state
);

    typedef struct packed {
        tap_st_e st;
    } fsm_regs_t;

    fsm_regs_t r_d, r_q;

    always_comb begin
        r_d    = r_q;
        r_d.st = tap_next(r_q.st, tms);
    end

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) r_q <= '{st: ST_RESET};
        else         r_q <= r_d;
    end

    assign state = r_q.st;

    // checker: run of TMS ones seen at rising edges, saturating at five
    logic [2:0] ones_q;
    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n)           ones_q <= 3'd0;
        else if (!tms)         ones_q <= 3'd0;
        else if (ones_q < 3'd5) ones_q <= ones_q + 3'd1;
    end

    a_r3_five_ones_reset: assert property (@(posedge tck) disable iff (!trst_n)
        (ones_q == 3'd5) |-> (r_q.st == ST_RESET));

    a_r2_reset_exit_idle: assert property (@(posedge tck) disable iff (!trst_n)
        (r_q.st == ST_RESET && !tms) |=> (r_q.st == ST_IDLE));

endmodule

// File: rtl/tap_port_ir.sv
module tap_port_ir
    import tap_port_pkg::*;
(
    input  logic     tck,
    input  logic     trst_n,
    input  logic     tdi,
    input  tap_st_e  state,
    output logic     ir_msb,
    output dr_path_e dr_path,
    output logic     hiz_req
);

    typedef struct packed {
        logic [IR_W-1:0] sh;
        logic [IR_W-1:0] lat;
    } ir_regs_t;

    ir_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        case (state)
            ST_RESET:  r_d.lat = OP_IDC;
            ST_CAP_IR: r_d.sh  = IR_CAPTURE;
            ST_SH_IR:  r_d.sh  = {r_q.sh[IR_W-2:0], tdi};
            ST_UPD_IR: r_d.lat = r_q.sh;
            default:   ;
        endcase
    end

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) r_q <= '{sh: IR_CAPTURE, lat: OP_IDC};
        else         r_q <= r_d;
    end

    always_comb begin
        hiz_req = 1'b0;
        case (r_q.lat)
            OP_IDC:  dr_path = PATH_ID;
            OP_SAMP: dr_path = PATH_SMP;
            OP_SAMZ: begin
                dr_path = PATH_SMP;
                hiz_req = 1'b1;
            end
            default: dr_path = PATH_BYP;
        endcase
    end

    assign ir_msb = r_q.sh[IR_W-1];

    a_r6_capture_pattern: assert property (@(posedge tck) disable iff (!trst_n)
        (state == ST_CAP_IR) |=> (r_q.sh == IR_CAPTURE));

    a_r6_latch_holds: assert property (@(posedge tck) disable iff (!trst_n)
        (state != ST_UPD_IR && state != ST_RESET) |=> $stable(r_q.lat));

    a_r3_reset_picks_id: assert property (@(posedge tck) disable iff (!trst_n)
        (state == ST_RESET) |=> (dr_path == PATH_ID && !hiz_req));

endmodule

// File: rtl/tap_port_dr.sv
module tap_port_dr
    import tap_port_pkg::*;
#(
    parameter int          SAMPLE_W = 8,
    parameter logic [3:0]  REV_ID   = 4'h1,
    parameter logic [15:0] PART_ID  = 16'h0001,
    parameter logic [10:0] MAKER_ID = 11'h001
) (
    input  logic                tck,
    input  logic                trst_n,
    input  logic                tdi,
    input  tap_st_e             state,
    input  dr_path_e            dr_path,
    input  logic [SAMPLE_W-1:0] sample_in,
    output logic                dr_msb
);

    localparam logic [ID_W-1:0] ID_WORD = {REV_ID, PART_ID, MAKER_ID, 1'b1};

    typedef struct packed {
        logic                byp;
        logic [ID_W-1:0]     id;
        logic [SAMPLE_W-1:0] smp;
    } dr_regs_t;

    dr_regs_t r_d, r_q;

    logic [SAMPLE_W-1:0] smp_shifted;

    generate
        if (SAMPLE_W > 1) begin : g_wide
            assign smp_shifted = {r_q.smp[SAMPLE_W-2:0], tdi};
        end else begin : g_single
            assign smp_shifted = tdi;
        end
    endgenerate

    always_comb begin
        r_d = r_q;
        if (state == ST_CAP_DR) begin
            case (dr_path)
                PATH_ID:  r_d.id  = ID_WORD;
                PATH_SMP: r_d.smp = sample_in;
                default:  r_d.byp = 1'b0;
            endcase
        end else if (state == ST_SH_DR) begin
            case (dr_path)
                PATH_ID:  r_d.id  = {r_q.id[ID_W-2:0], tdi};
                PATH_SMP: r_d.smp = smp_shifted;
                default:  r_d.byp = tdi;
            endcase
        end
    end

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) r_q <= '{byp: 1'b0, id: ID_WORD, smp: '0};
        else         r_q <= r_d;
    end

    always_comb begin
        case (dr_path)
            PATH_ID:  dr_msb = r_q.id[ID_W-1];
            PATH_SMP: dr_msb = r_q.smp[SAMPLE_W-1];
            default:  dr_msb = r_q.byp;
        endcase
    end

    a_r8_bypass_zero: assert property (@(posedge tck) disable iff (!trst_n)
        (state == ST_CAP_DR && dr_path == PATH_BYP) |=> !r_q.byp);

    a_r5_lsb_entry: assert property (@(posedge tck) disable iff (!trst_n)
        (state == ST_SH_DR && dr_path == PATH_ID) |=> (r_q.id[0] == $past(tdi)));

    a_r10_snapshot: assert property (@(posedge tck) disable iff (!trst_n)
        (state == ST_CAP_DR && dr_path == PATH_SMP) |=> (r_q.smp == $past(sample_in)));

    a_r9_id_lsb: assert property (@(posedge tck) disable iff (!trst_n)
        (state == ST_CAP_DR && dr_path == PATH_ID) |=> r_q.id[0]);

endmodule

// File: rtl/tap_port.sv
module tap_port
    import tap_port_pkg::*;
#(
    parameter int          SAMPLE_W = 8,
    parameter logic [3:0]  REV_ID   = 4'h1,
    parameter logic [15:0] PART_ID  = 16'h0001,
    parameter logic [10:0] MAKER_ID = 11'h001
) (
    input  logic                tck,
    input  logic                trst_n,
    input  logic                tms,
    input  logic                tdi,
    input  logic [SAMPLE_W-1:0] sample_in,
    output logic                tdo,
    output logic                tdo_en,
    output logic                outputs_hiz
);

    tap_st_e  state;
    dr_path_e dr_path;
    logic     ir_msb;
    logic     dr_msb;

    tap_port_fsm u_fsm (
        .tck    (tck),
        .trst_n (trst_n),
        .tms    (tms),
        .state  (state)
    );

    tap_port_ir u_ir (
        .tck     (tck),
        .trst_n  (trst_n),
        .tdi     (tdi),
        .state   (state),
        .ir_msb  (ir_msb),
        .dr_path (dr_path),
        .hiz_req (outputs_hiz)
    );

    tap_port_dr #(
        .SAMPLE_W (SAMPLE_W),
        .REV_ID   (REV_ID),
        .PART_ID  (PART_ID),
        .MAKER_ID (MAKER_ID)
    ) u_dr (
        .tck       (tck),
        .trst_n    (trst_n),
        .tdi       (tdi),
        .state     (state),
        .dr_path   (dr_path),
        .sample_in (sample_in),
        .dr_msb    (dr_msb)
    );

    // falling-edge output stage
    typedef struct packed {
        logic bit_o;
        logic en;
    } out_regs_t;

    out_regs_t o_d, o_q;

    always_comb begin
        o_d.en    = (state == ST_SH_IR) || (state == ST_SH_DR);
        o_d.bit_o = (state == ST_SH_IR) ? ir_msb : dr_msb;
    end

    always_ff @(negedge tck or negedge trst_n) begin
        if (!trst_n) o_q <= '{bit_o: 1'b0, en: 1'b0};
        else         o_q <= o_d;
    end

    assign tdo    = o_q.bit_o;
    assign tdo_en = o_q.en;

    a_r4_enable_in_shift: assert property (@(posedge tck) disable iff (!trst_n)
        tdo_en |-> (state == ST_SH_IR || state == ST_SH_DR));

    a_r11_hiz_after_update: assert property (@(posedge tck) disable iff (!trst_n)
        $rose(outputs_hiz) |-> ($past(state) == ST_UPD_IR));

endmodule

// File: tb/tap_port_test.sv
module tap_port_test;

    localparam int          CLK_PERIOD = 10;
    localparam int          SW         = 12;
    localparam logic [3:0]  T_REV      = 4'h9;
    localparam logic [15:0] T_PART     = 16'hC3A1;
    localparam logic [10:0] T_MAKER    = 11'h2B5;
    localparam logic [31:0] T_ID       = {T_REV, T_PART, T_MAKER, 1'b1};

    logic          tck = 1'b0;
    logic          trst_n = 1'b0;
    logic          tms = 1'b1;
    logic          tdi = 1'b0;
    logic [SW-1:0] sample_in = '0;
    logic          tdo, tdo_en, outputs_hiz;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    tap_port #(
        .SAMPLE_W (SW),
        .REV_ID   (T_REV),
        .PART_ID  (T_PART),
        .MAKER_ID (T_MAKER)
    ) uut (
        .tck         (tck),
        .trst_n      (trst_n),
        .tms         (tms),
        .tdi         (tdi),
        .sample_in   (sample_in),
        .tdo         (tdo),
        .tdo_en      (tdo_en),
        .outputs_hiz (outputs_hiz)
    );

    always #(CLK_PERIOD/2) tck = ~tck;

    typedef struct {
        logic  v;
        logic  en;
        bit    chkv;
        string tag;
    } exp_t;

    exp_t sb_q[$];

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // monitor: each expected item is due right after the next falling edge
    initial begin
        forever begin
            @(negedge tck);
            #2;
            if (sb_q.size() > 0) begin
                exp_t it;
                it = sb_q.pop_front();
                check(tdo_en === it.en, {it.tag, " tdo_en"}, {31'd0, tdo_en}, {31'd0, it.en});
                if (it.chkv)
                    check(tdo === it.v, {it.tag, " tdo"}, {31'd0, tdo}, {31'd0, it.v});
            end
        end
    end

    task automatic step(input logic m, input logic d);
        @(negedge tck);
        #4;
        tms = m;
        tdi = d;
    endtask

    task automatic step_x(input logic m, input logic d, input logic v, input logic en,
                          input bit chkv, input string tag);
        exp_t it;
        it.v = v; it.en = en; it.chkv = chkv; it.tag = tag;
        sb_q.push_back(it);
        step(m, d);
    endtask

    // from Run-Test/Idle: capture, shift len bits, update, back to idle
    task automatic dr_scan(input int len, input logic [63:0] din, input logic [63:0] dout,
                           input string tag);
        step(1, 0);
        step(0, 0);
        step(0, 0);
        for (int i = 0; i < len; i++)
            step_x(i == len - 1, din[i], dout[i], 1'b1, 1'b1, tag);
        step_x(1, 0, 1'b0, 1'b0, 1'b0, "R4 exit1-dr");
        step(0, 0);
    endtask

    // from Run-Test/Idle: load an instruction through the pause detour
    task automatic ir_load(input logic [2:0] code, input logic hiz_before, input logic hiz_after,
                           input string tag);
        step(1, 0);
        step(1, 0);
        step(0, 0);
        step(0, 0);
        for (int i = 0; i < 3; i++)
            step_x(i == 2, code[2-i], (i == 2), 1'b1, 1'b1, "R6 ir capture 001");
        step_x(0, 0, 1'b0, 1'b0, 1'b0, "R4 exit1-ir");
        step(0, 0);
        check(outputs_hiz === hiz_before, "R6 instruction held in pause-ir",
              {31'd0, outputs_hiz}, {31'd0, hiz_before});
        step(1, 0);
        step(1, 0);
        step(0, 0);
        step(0, 0);
        check(outputs_hiz === hiz_after, {tag, " hiz after update"},
              {31'd0, outputs_hiz}, {31'd0, hiz_after});
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    function automatic logic [63:0] id_out();
        logic [63:0] r = '0;
        for (int i = 0; i < 32; i++) r[i] = T_ID[31-i];
        return r;
    endfunction

    function automatic logic [63:0] smp_out(input logic [SW-1:0] a);
        logic [63:0] r = '0;
        for (int i = 0; i < SW; i++) r[i] = a[SW-1-i];
        return r;
    endfunction

    function automatic logic [63:0] byp_out(input logic [63:0] din);
        logic [63:0] r = '0;
        for (int i = 1; i < 64; i++) r[i] = din[i-1];
        return r;
    endfunction

    initial begin
        logic [2:0]  byp_codes [5];
        logic [63:0] pat;
        byp_codes = '{3'd0, 3'd3, 3'd5, 3'd6, 3'd7};

        repeat (3) @(posedge tck);
        #2;
        // R1: reset state
        check(tdo_en === 1'b0, "R1 tdo_en in reset", {31'd0, tdo_en}, 32'd0);
        check(outputs_hiz === 1'b0, "R1 hiz in reset", {31'd0, outputs_hiz}, 32'd0);
        @(negedge tck);
        #4;
        trst_n = 1'b1;
        tms = 1'b1;

        step(0, 0);   // reset -> idle
        step_x(0, 0, 1'b0, 1'b0, 1'b0, "R4 idle no drive");
        // R1 R9 R5: identity selected by default, MSB first
        dr_scan(32, 64'h0, id_out(), "R9 id word");

        // R7 R8: bypass codes, including private
        foreach (byp_codes[k]) begin
            pat = 64'h0 | (8'hA5 ^ (8'h3C * k));
            ir_load(byp_codes[k], 1'b0, 1'b0, "R7 bypass code");
            dr_scan(8, pat, byp_out(pat), "R8 one-stage bypass");
        end

        // R7 R10: sample, capture held when sample_in moves during shift
        ir_load(3'd4, 1'b0, 1'b0, "R11 sample no hiz");
        sample_in = 12'hB4E;
        fork
            dr_scan(SW, 64'h0, smp_out(12'hB4E), "R10 sample capture");
            begin
                repeat (5) @(posedge tck);
                #1 sample_in = 12'h3C1;
            end
        join
        dr_scan(SW, 64'h0, smp_out(12'h3C1), "R10 sample second pattern");

        // R11: sample with float
        ir_load(3'd2, 1'b0, 1'b1, "R11 samplez hiz");
        sample_in = 12'h5A7;
        dr_scan(SW, 64'h0, smp_out(12'h5A7), "R7 samplez selects sample");

        // R3: four ones from shift-dr do not reset
        step(1, 0);
        step(0, 0);
        step(0, 0);   // now shift-dr
        step(1, 0);   // exit1
        step(1, 0);   // update
        step(1, 0);   // select-dr
        step(1, 0);   // select-ir
        step(0, 0);   // capture-ir
        step(0, 0);   // shift-ir
        for (int i = 0; i < 3; i++)
            step_x(i == 2, 3'd2 >> (2 - i), (i == 2), 1'b1, 1'b1, "R3 four ones reach ir path");
        step(1, 0);   // update-ir
        step(0, 0);   // idle
        step(0, 0);
        check(outputs_hiz === 1'b1, "R3 four ones keep instruction",
              {31'd0, outputs_hiz}, 32'd1);

        // R3: five ones from shift-dr reset and restore identity
        step(1, 0);
        step(0, 0);
        step(0, 0);   // shift-dr
        for (int i = 0; i < 5; i++) step(1, 0);
        step(0, 0);
        step(0, 0);
        check(outputs_hiz === 1'b0, "R3 five ones clear hiz", {31'd0, outputs_hiz}, 32'd0);
        dr_scan(32, 64'h0, id_out(), "R3 identity after five ones");

        // R2: pause-dr detour keeps the bypass stream intact
        ir_load(3'd7, 1'b0, 1'b0, "R7 bypass code 7");
        step(1, 0);
        step(0, 0);
        step(0, 0);
        step_x(0, 1, 1'b0, 1'b1, 1'b1, "R2 pause path bit0");
        step_x(1, 0, 1'b1, 1'b1, 1'b1, "R2 pause path bit1");
        step_x(0, 0, 1'b0, 1'b0, 1'b0, "R4 exit1 pause");
        step_x(1, 0, 1'b0, 1'b0, 1'b0, "R4 pause-dr");
        step_x(0, 0, 1'b0, 1'b0, 1'b0, "R4 exit2-dr");
        step_x(1, 1, 1'b0, 1'b1, 1'b1, "R2 resumed shift");
        step_x(1, 0, 1'b1, 1'b0, 1'b0, "R4 exit1 after resume");
        step(0, 0);
        step(0, 0);

        repeat (3) @(posedge tck);
        check(sb_q.size() == 0, "R4 scoreboard drained", sb_q.size(), 32'd0);
        finish_run();
    end

endmodule